// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits on the controller side of an SDRAM interface, between a command scheduler and the command pins. It keeps an open/closed flag and the open row for every bank, and it holds back any command whose minimum cycle spacing has not yet elapsed. Four spacings are enforced: row-open to column access within a bank, row-open to row-open within a bank, row-open to row-open across banks, and bank-close to row-open within a bank. All of them are given as whole clock cycles, already converted from nanoseconds by rounding up.

A requester presents one command per cycle with a bank and a row. In the same cycle the block answers in one of three ways. It grants the command, which appears on the registered pins one cycle later. It stalls the command (ready low), and the requester holds it until it is granted. Or it rejects the command as illegal (ready and error high), and nothing is issued. Because each bank keeps its own row state and its own timers, rows in other banks can be opened and used while one bank's row stays open.

Top module: `sdram_act_guard`

## Requirements
- R1: While rst_n is low and on the first cycle after it, the pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111) and cke is low. After reset, cke is high.
- R2: req_cmd codes are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE. Codes 5 to 7 behave as NOP. A granted command is driven as {cs_n,ras_n,cas_n,we_n}: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, NOP 0111.
- R3: A READ or WRITE to a bank with no open row is rejected (req_ready=1, req_err=1), and the pins carry NOP on the next cycle.
- R4: A READ or WRITE whose row differs from the open row of its bank is rejected with req_err and is not issued.
- R5: A READ or WRITE to a bank is granted no earlier than T_RCD (3) cycles after the ACTIVE that opened that bank was granted.
- R6: An ACTIVE to a bank that already has an open row is rejected with req_err and is not issued.
- R7: Two ACTIVE grants to the same bank are at least T_RC (8) cycles apart.
- R8: Two ACTIVE grants to any banks are at least T_RRD (2) cycles apart.
- R9: PRECHARGE is always granted and closes its bank. An ACTIVE to that bank is granted no earlier than T_RP (3) cycles after it.
- R10: A request that is legal apart from timing sees req_ready low. The pins carry NOP for every stalled cycle, and the held request is granted in the first cycle in which all its timers have expired.
- R11: While one bank is open and within its own timers, ACTIVE and READ to other banks are granted as soon as their own constraints allow.
- R12: A command granted at a clock edge appears on the pins during the following cycle, with ba equal to its bank. addr equals the row for ACTIVE and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A command is presented |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row address |
| req_ready | output | 1 | Request consumed this cycle (granted or rejected) |
| req_err | output | 1 | Request rejected as illegal |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address pins |
| addr | output | 12 | Address pins |

## Verification
The case hardest to reach from the ports is a same-bank ACTIVE that is still blocked by the row cycle time after the bank-close delay has already run out. It only appears when an ACTIVE, an immediate PRECHARGE and a re-ACTIVE to the same bank are presented back to back. The bench drives exactly that sequence and counts the stall cycles (six with the default timings), and it checks that NOP is on the pins throughout. A separate sequence idles long enough for the row cycle to expire before closing the bank, so that only the bank-close delay is left to be measured.

// File: rtl/sdram_guard_pkg.sv
// Package: shared command codes and pin encodings for the activation guard.
// Assumes active-low command pins ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_guard_pkg;

    typedef enum logic [2:0] {
        REQ_NOP = 3'd0,
        REQ_ACT = 3'd1,
        REQ_RD  = 3'd2,
        REQ_WR  = 3'd3,
        REQ_PRE = 3'd4
    } req_cmd_e;

    localparam logic [3:0] PINS_NOP = 4'b0111;
    localparam logic [3:0] PINS_ACT = 4'b0011;
    localparam logic [3:0] PINS_RD  = 4'b0101;
    localparam logic [3:0] PINS_WR  = 4'b0100;
    localparam logic [3:0] PINS_PRE = 4'b0010;

    // Map a request code onto the four command pins.
    function automatic logic [3:0] pins_of(input logic [2:0] c);
        case (c)
            REQ_ACT: pins_of = PINS_ACT;
            REQ_RD:  pins_of = PINS_RD;
            REQ_WR:  pins_of = PINS_WR;
            REQ_PRE: pins_of = PINS_PRE;
            default: pins_of = PINS_NOP;
        endcase
    endfunction

endpackage

// File: rtl/guard_timer.sv
// Module: guard_timer
// Down-counter that blocks for SPAN cycles after a start pulse. done is high
// when a dependent command may be granted at the coming clock edge.
// Assumes SPAN >= 1; a start while counting restarts the window.
module guard_timer #(
    parameter int SPAN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [CW-1:0] LOADV = CW'(SPAN - 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOADV;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/bank_slot.sv
// Module: bank_slot
// State of one bank: open flag, open row, and the per-bank timers for
// open-to-access, open-to-open and close-to-open spacing.
// Assumes do_act and do_pre are never high together.
module bank_slot #(
    parameter int ROW_W = 12,
    parameter int T_RCD = 3,
    parameter int T_RC  = 8,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rcd_ok,
    output logic             rc_ok,
    output logic             rp_ok
);
    // Track the open flag and latch the row on activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (do_act) begin
            is_open  <= 1'b1;
            open_row <= act_row;
        end else if (do_pre) begin
            is_open  <= 1'b0;
        end
    end

    guard_timer #(.SPAN(T_RCD)) u_rcd (.clk(clk), .rst_n(rst_n), .start(do_act), .done(rcd_ok));
    guard_timer #(.SPAN(T_RC))  u_rc  (.clk(clk), .rst_n(rst_n), .start(do_act), .done(rc_ok));
    guard_timer #(.SPAN(T_RP))  u_rp  (.clk(clk), .rst_n(rst_n), .start(do_pre), .done(rp_ok));
endmodule

// File: rtl/cmd_pins.sv
// Module: cmd_pins
// Registers the granted command onto the SDRAM pins; NOP when nothing issues.
// Assumes cmd is a request code from sdram_guard_pkg.
module cmd_pins #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [2:0]       cmd,
    input  logic [BA_W-1:0]  bank,
    input  logic [ROW_W-1:0] row,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr
);
    import sdram_guard_pkg::*;

    // Drive pins one cycle after the grant decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke <= 1'b0;
            {cs_n, ras_n, cas_n, we_n} <= PINS_NOP;
            ba   <= '0;
            addr <= '0;
        end else begin
            cke <= 1'b1;
            if (issue) begin
                {cs_n, ras_n, cas_n, we_n} <= pins_of(cmd);
                ba   <= bank;
                addr <= (cmd == REQ_ACT) ? row : '0;
            end else begin
                {cs_n, ras_n, cas_n, we_n} <= PINS_NOP;
                ba   <= '0;
                addr <= '0;
            end
        end
    end
endmodule

// File: rtl/sdram_act_guard.sv
// Module: sdram_act_guard (top)
// Grants, stalls or rejects one requested SDRAM command per cycle against
// per-bank row state and the activation spacing timers, and drives the pins.
// Assumes timing parameters are whole cycles >= 1 and the requester holds a
// stalled request unchanged until req_ready.
module sdram_act_guard #(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 12,
    parameter int T_RCD  = 3,
    parameter int T_RC   = 8,
    parameter int T_RRD  = 2,
    parameter int T_RP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_cmd,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    output logic             req_ready,
    output logic             req_err,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [BA_W-1:0]  ba,
    output logic [ROW_W-1:0] addr
);
    import sdram_guard_pkg::*;

    localparam int NB = 1 << BA_W;

    logic [NB-1:0]    open_v, rcd_v, rc_v, rp_v, act_v, pre_v;
    logic [ROW_W-1:0] row_v [NB];
    logic             rrd_ok;
    logic             issue, illegal, stall, is_act, is_pre;

    // One state slot per bank.
    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign act_v[b] = issue && is_act && (req_bank == BA_W'(b));
        assign pre_v[b] = issue && is_pre && (req_bank == BA_W'(b));
        bank_slot #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .do_act(act_v[b]), .do_pre(pre_v[b]), .act_row(req_row),
            .is_open(open_v[b]), .open_row(row_v[b]),
            .rcd_ok(rcd_v[b]), .rc_ok(rc_v[b]), .rp_ok(rp_v[b])
        );
    end

    // Cross-bank activation spacing.
    guard_timer #(.SPAN(T_RRD)) u_rrd (.clk(clk), .rst_n(rst_n), .start(issue && is_act), .done(rrd_ok));

    // Classify the current request as legal, timing-blocked or illegal.
    always_comb begin
        is_act  = (req_cmd == REQ_ACT);
        is_pre  = (req_cmd == REQ_PRE);
        illegal = 1'b0;
        stall   = 1'b0;
        case (req_cmd)
            REQ_ACT: begin
                if (open_v[req_bank])
                    illegal = 1'b1;
                else if (!(rc_v[req_bank] && rp_v[req_bank] && rrd_ok))
                    stall = 1'b1;
            end
            REQ_RD, REQ_WR: begin
                if (!open_v[req_bank] || (row_v[req_bank] != req_row))
                    illegal = 1'b1;
                else if (!rcd_v[req_bank])
                    stall = 1'b1;
            end
            default: ;
        endcase
        issue     = req_valid && !illegal && !stall;
        req_ready = req_valid && !stall;
        req_err   = req_valid && illegal;
    end

    cmd_pins #(.BA_W(BA_W), .ROW_W(ROW_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .issue(issue), .cmd(req_cmd),
        .bank(req_bank), .row(req_row), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );
endmodule

// File: rtl/sdram_act_guard_chk.sv
// Module: sdram_act_guard_chk
// Checker bound to sdram_act_guard: watches the pins and measures command
// spacing with its own saturating counters. Assumes the default pin order.
module sdram_act_guard_chk #(
    parameter int BA_W  = 2,
    parameter int ROW_W = 12,
    parameter int T_RCD = 3,
    parameter int T_RC  = 8,
    parameter int T_RRD = 2,
    parameter int T_RP  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_cmd,
    input logic [BA_W-1:0]  req_bank,
    input logic             req_ready,
    input logic             req_err,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [BA_W-1:0]  ba
);
    localparam int NB = 1 << BA_W;
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [3:0]  pins;
    logic        p_act, p_pre, p_col, p_nop;
    logic [15:0] since_act [NB];
    logic [15:0] since_pre [NB];
    logic [15:0] since_any;

    assign pins  = {cs_n, ras_n, cas_n, we_n};
    assign p_act = (pins == 4'b0011);
    assign p_pre = (pins == 4'b0010);
    assign p_col = (pins == 4'b0101) || (pins == 4'b0100);
    assign p_nop = (pins == 4'b0111);

    // Cycles since the last ACTIVE and PRECHARGE seen on the pins per bank.
    for (genvar b = 0; b < NB; b++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                since_act[b] <= SAT;
                since_pre[b] <= SAT;
            end else begin
                if (p_act && ba == BA_W'(b)) since_act[b] <= 16'd1;
                else if (since_act[b] != SAT) since_act[b] <= since_act[b] + 1'b1;
                if (p_pre && ba == BA_W'(b)) since_pre[b] <= 16'd1;
                else if (since_pre[b] != SAT) since_pre[b] <= since_pre[b] + 1'b1;
            end
        end
    end

    // Cycles since any ACTIVE on the pins.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_any <= SAT;
        else if (p_act)          since_any <= 16'd1;
        else if (since_any != SAT) since_any <= since_any + 1'b1;
    end

    assert_rcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        p_col |-> since_act[ba] >= 16'(T_RCD));
    assert_rc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        p_act |-> since_act[ba] >= 16'(T_RC));
    assert_rrd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        p_act |-> since_any >= 16'(T_RRD));
    assert_rp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        p_act |-> since_pre[ba] >= 16'(T_RP));
    assert_stall_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> p_nop);
    assert_reject_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> p_nop);
    assert_grant_bank_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_err && req_cmd == 3'd1) |=> (p_act && ba == $past(req_bank)));
endmodule

bind sdram_act_guard sdram_act_guard_chk #(
    .BA_W(BA_W), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RP(T_RP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_ready(req_ready), .req_err(req_err),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba)
);

// File: tb/sdram_act_guard_tb.sv
// Directed bench for sdram_act_guard: one task per scenario.
module sdram_act_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [11:0] req_row = 12'd0;
    logic        req_ready, req_err, cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_act_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_row(req_row), .req_ready(req_ready),
        .req_err(req_err), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

    // Expected pin code for a request code.
    function automatic logic [3:0] exp_pins(input logic [2:0] c);
        case (c)
            C_ACT:   return 4'b0011;
            C_RD:    return 4'b0101;
            C_WR:    return 4'b0100;
            C_PRE:   return 4'b0010;
            default: return 4'b0111;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a request at a falling edge and hold it until consumed.
    // Reports stall cycles, the error flag, pins of the next cycle, and
    // whether any stalled cycle showed pins other than NOP.
    task automatic send(input logic [2:0] c, input logic [1:0] b, input logic [11:0] r,
                        output int waits, output bit err, output logic [3:0] pins,
                        output logic [1:0] pba, output logic [11:0] paddr, output bit stall_bad);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_row = r;
        waits = 0; stall_bad = 1'b0;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
            waits++;
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) stall_bad = 1'b1;
            if (waits > 100) break;
        end
        err = req_err;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        pins = {cs_n, ras_n, cas_n, we_n}; pba = ba; paddr = addr;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int w; bit e, sb; logic [3:0] p; logic [1:0] pb; logic [11:0] pa;

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pins in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        check("R1 cke in reset", cke, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 cke after reset", cke, 1);
        check("R1 pins after reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    endtask

    task automatic t_closed_access();
        send(C_RD, 2'd0, 12'h155, w, e, p, pb, pa, sb);
        check("R3 read closed err", e, 1);
        check("R3 read closed pins", p, 4'b0111);
    endtask

    task automatic t_open_and_read();
        send(C_ACT, 2'd0, 12'h155, w, e, p, pb, pa, sb);
        check("R2 act pins", p, exp_pins(C_ACT));
        check("R12 act addr", pa, 12'h155);
        check("R12 act ba", pb, 0);
        check("R12 act no stall", w, 0);
        send(C_RD, 2'd0, 12'h155, w, e, p, pb, pa, sb);
        check("R5 read stall cycles", w, 2);
        check("R2 read pins", p, exp_pins(C_RD));
        check("R12 read addr zero", pa, 0);
        send(C_WR, 2'd0, 12'h0AA, w, e, p, pb, pa, sb);
        check("R4 row miss err", e, 1);
        check("R4 row miss pins", p, 4'b0111);
        send(C_WR, 2'd0, 12'h155, w, e, p, pb, pa, sb);
        check("R2 write pins", p, exp_pins(C_WR));
        send(C_ACT, 2'd0, 12'h033, w, e, p, pb, pa, sb);
        check("R6 act open bank err", e, 1);
        check("R6 act open bank pins", p, 4'b0111);
    endtask

    task automatic t_overlap();
        idle(5);
        send(C_ACT, 2'd2, 12'h020, w, e, p, pb, pa, sb);
        check("R11 act bank2", p, exp_pins(C_ACT));
        send(C_ACT, 2'd3, 12'h030, w, e, p, pb, pa, sb);
        check("R8 cross bank stall", w, 1);
        check("R8 act bank3 ba", pb, 3);
        send(C_RD, 2'd2, 12'h020, w, e, p, pb, pa, sb);
        check("R11 read bank2 no stall", w, 0);
        check("R11 read bank2 pins", p, exp_pins(C_RD));
        send(C_RD, 2'd3, 12'h030, w, e, p, pb, pa, sb);
        check("R5 read bank3 stall", w, 1);
    endtask

    task automatic t_row_cycle();
        idle(10);
        send(C_ACT, 2'd1, 12'h001, w, e, p, pb, pa, sb);
        send(C_PRE, 2'd1, 12'h000, w, e, p, pb, pa, sb);
        check("R9 pre granted", w, 0);
        check("R2 pre pins", p, exp_pins(C_PRE));
        send(C_ACT, 2'd1, 12'h002, w, e, p, pb, pa, sb);
        check("R7 same bank stall", w, 6);
        check("R10 stall pins nop", sb, 0);
        check("R10 granted after stall", p, exp_pins(C_ACT));
    endtask

    task automatic t_close_delay();
        idle(10);
        send(C_PRE, 2'd1, 12'h000, w, e, p, pb, pa, sb);
        send(C_RD, 2'd1, 12'h002, w, e, p, pb, pa, sb);
        check("R9 closed read err", e, 1);
        send(C_ACT, 2'd1, 12'h004, w, e, p, pb, pa, sb);
        check("R9 precharge stall", w, 1);
        check("R9 reopen addr", pa, 12'h004);
    endtask

    task automatic t_nop();
        send(3'd6, 2'd0, 12'h0FF, w, e, p, pb, pa, sb);
        check("R2 unused code ready", w, 0);
        check("R2 unused code pins", p, 4'b0111);
        check("R2 unused code no err", e, 0);
    endtask

    initial begin
        t_reset();
        t_closed_access();
        t_open_and_read();
        t_overlap();
        t_row_cycle();
        t_close_delay();
        t_nop();
        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule